// File: doc/BRIEF.md
# Software-Clocked Management Bus Port

This block lets a processor run a two-wire station management bus by toggling the pins itself. It sits behind a 32-bit register bus and decodes a window of 0x5C bytes. Inside that window there are two live words.

Writing the control word (byte offset 0x28) sets the management clock level, sets the output-enable of the bidirectional data pin, and can also update the data value driven on that pin. Every clock edge on the bus comes from one such write; the block generates no timing of its own. Reading the status word (byte offset 0x2C) returns the data pin's level, passed through a synchronizer. Software builds a whole frame from a sequence of writes and reads: preamble, start, opcode, addresses, turnaround and data.

The block accepts only aligned, full-word accesses inside its window. Any other access changes nothing, reads back as zero, and raises a one-cycle error pulse.

Top module: `mdio_bitbang_port`

## Requirements
- R1: While reset is asserted and right after it, the clock output is low, output-enable is low, the data output is 0, read data is zero and the error flag is low.
- R2: A legal write to offset 0x28 sets the clock output to bit 2 of the written word from the next cycle on.
- R3: A legal write to offset 0x28 sets output-enable to bit 1 of the word. The data output takes bit 0 only when bit 1 is 1. When bit 1 is 0 the data output keeps its previous value.
- R4: The clock output changes only through a legal control write whose bit 2 differs from the present clock level. All other cycles leave it unchanged.
- R5: A legal read of offset 0x2C returns, one cycle after the read strobe, the data-pin level in bit 0 with bits 31:1 zero. That level is the input sampled SYNC_STAGES clock edges before the read edge.
- R6: A legal read of offset 0x28 returns, one cycle later, the clock level in bit 2, output-enable in bit 1 and the data output in bit 0, with the upper bits zero.
- R7: Legal accesses to any other word in the window have no effect on the outputs, read as zero and raise no error.
- R8: An access is illegal if the byte enables are not all four set, the address bits 1:0 are not 00, or the address is at or above 0x5C. An illegal write changes nothing. An illegal read returns zero. The error flag is high for exactly the one cycle after any illegal access.
- R9: When a read and a control write fall in the same cycle, the read returns the state from before that write.
- R10: Read data holds its last value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address within the window |
| reg_be | input | DATA_W/8 | Byte enables; all set for a legal access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| acc_err | output | 1 | One-cycle pulse after an illegal access |
| mdc_o | output | 1 | Management clock level |
| mdio_out_o | output | 1 | Data value for the bidirectional pin |
| mdio_oe_o | output | 1 | Output enable for the bidirectional pin |
| mdio_in_i | input | 1 | Level sensed on the bidirectional pin |

## Verification
Two functions can share a cycle: a control write can coincide with a read of the control or status word, and an illegal access can combine both strobes at once. The bench drives both strobes together with a pseudo-random mix of offsets, byte enables and data. A behavioural model updates from the pre-edge state and predicts that the read returns the old control bits, while the write lands in the outputs one cycle later. The model is compared on every clock, and a directed same-cycle write-and-read checks the old-value rule explicitly.

// File: rtl/mdio_bb_pkg.sv
package mdio_bb_pkg;

  localparam int CTRL_OFF  = 'h28;
  localparam int STAT_OFF  = 'h2C;
  localparam int WIN_BYTES = 'h5C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

  // Packed so that clk sits in bit 2, drive in bit 1, data in bit 0.
  typedef struct packed {
    logic clk;
    logic drive;
    logic data;
  } mgmt_ctrl_t;

  localparam mgmt_ctrl_t CTRL_RESET = '{clk: 1'b0, drive: 1'b0, data: 1'b0};

  // Next control state for a control write of the three low bits.
  function automatic mgmt_ctrl_t next_ctrl(mgmt_ctrl_t cur, logic [2:0] w);
    mgmt_ctrl_t res;
    res.clk   = w[2];
    res.drive = w[1];
    res.data  = w[1] ? w[0] : cur.data;
    return res;
  endfunction

  // A clock edge happens when the requested level differs from the present one.
  function automatic logic clk_toggles(mgmt_ctrl_t cur, logic [2:0] w);
    return cur.clk != w[2];
  endfunction

  // Legality of one access: full word, aligned, inside the window.
  function automatic logic access_legal(logic [31:0] byte_addr, logic all_lanes);
    return all_lanes && (byte_addr[1:0] == 2'b00) && (byte_addr < 32'(WIN_BYTES));
  endfunction

endpackage

// File: rtl/mdio_bb_decode.sv
module mdio_bb_decode
  import mdio_bb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              ctrl_we,
  output logic              bad
);

  logic [31:0] addr_ext;
  logic        legal;

  assign addr_ext = 32'(addr);
  assign legal    = access_legal(addr_ext, &be);

  always_comb begin
    sel = SEL_NONE;
    if (legal) begin
      if (addr_ext == 32'(CTRL_OFF))      sel = SEL_CTRL;
      else if (addr_ext == 32'(STAT_OFF)) sel = SEL_STAT;
    end
  end

  assign ctrl_we = wr && (sel == SEL_CTRL);
  assign bad     = (wr || rd) && !legal;

endmodule

// File: rtl/mdio_bb_ctrl.sv
module mdio_bb_ctrl
  import mdio_bb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wbits,
  output mgmt_ctrl_t state,
  output logic       clk_edge
);

  mgmt_ctrl_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= CTRL_RESET;
    else if (we) state_q <= next_ctrl(state_q, wbits);
  end

  assign state    = state_q;
  assign clk_edge = we && clk_toggles(state_q, wbits);

endmodule

// File: rtl/mdio_bb_sync.sv
module mdio_bb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mdio_bitbang_port.sv
module mdio_bitbang_port
  import mdio_bb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BE_W-1:0]   reg_be,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              acc_err,
  output logic              mdc_o,
  output logic              mdio_out_o,
  output logic              mdio_oe_o,
  input  logic              mdio_in_i
);

  reg_sel_e   sel;
  logic       ctrl_we;
  logic       acc_bad;
  logic       mdc_edge;
  logic       line_lvl;
  mgmt_ctrl_t ctrl;
  logic [2:0] wbits;
  logic       unused_wdata_hi;

  assign wbits           = reg_wdata[2:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:3];

  mdio_bb_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .addr    (reg_addr),
    .be      (reg_be),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .sel     (sel),
    .ctrl_we (ctrl_we),
    .bad     (acc_bad)
  );

  mdio_bb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctrl_we),
    .wbits    (wbits),
    .state    (ctrl),
    .clk_edge (mdc_edge)
  );

  mdio_bb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_in_i),
    .q     (line_lvl)
  );

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_CTRL: rd_word[2:0] = ctrl;
      SEL_STAT: rd_word[0]   = line_lvl;
      default:  rd_word      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_word;
      acc_err <= acc_bad;
    end
  end

  assign mdc_o      = ctrl.clk;
  assign mdio_oe_o  = ctrl.drive;
  assign mdio_out_o = ctrl.data;

endmodule

// File: rtl/mdio_bb_checker.sv
module mdio_bb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_we,
  input logic              acc_bad,
  input logic              mdc_edge,
  input logic [2:0]        wbits,
  input logic              mdc_o,
  input logic              mdio_out_o,
  input logic              mdio_oe_o,
  input logic              acc_err,
  input logic [DATA_W-1:0] reg_rdata
);

  AST_MDC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (mdc_o == $past(wbits[2]))); // R2

  AST_OE_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (mdio_oe_o == $past(wbits[1]))); // R3

  AST_OUT_HELD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wbits[1]) |=> $stable(mdio_out_o)); // R3

  AST_MDC_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(mdc_o)); // R4

  AST_EDGE_CHANGES_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_edge |=> (mdc_o != $past(mdc_o))); // R4

  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> acc_err); // R8

  AST_NO_ERR_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_bad |=> !acc_err); // R8

  AST_BAD_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |-> !ctrl_we); // R8

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:3] == '0); // R6

endmodule

bind mdio_bitbang_port mdio_bb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .acc_bad    (acc_bad),
  .mdc_edge   (mdc_edge),
  .wbits      (reg_wdata[2:0]),
  .mdc_o      (mdc_o),
  .mdio_out_o (mdio_out_o),
  .mdio_oe_o  (mdio_oe_o),
  .acc_err    (acc_err),
  .reg_rdata  (reg_rdata)
);

// File: tb/tb_mdio_bitbang_port.sv
module tb_mdio_bitbang_port;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        mdc, mout, moe;
  logic        min = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mdio_bitbang_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_be(be),
    .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata),
    .acc_err(err), .mdc_o(mdc), .mdio_out_o(mout), .mdio_oe_o(moe),
    .mdio_in_i(min)
  );

  // Behavioural reference model
  bit          m_mdc, m_oe, m_out, m_err;
  logic [31:0] m_rdata;
  bit          hist[$];

  function automatic bit legal(logic [7:0] a, logic [3:0] b);
    return (b == 4'hF) && (a % 4 == 0) && (int'(a) < 92);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mdc = 0; m_oe = 0; m_out = 0; m_err = 0; m_rdata = 0;
      hist.delete();
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b0);
    end else begin
      bit ok;
      bit seen;
      ok = legal(addr, be);
      seen = hist[SYNC-1];
      if (rd) begin
        if (!ok)              m_rdata = 0;
        else if (addr == 40)  m_rdata = {29'd0, m_mdc, m_oe, m_out};
        else if (addr == 44)  m_rdata = {31'd0, seen};
        else                  m_rdata = 0;
      end
      if (wr && ok && addr == 40) begin
        m_mdc = wdata[2];
        m_oe  = wdata[1];
        if (wdata[1]) m_out = wdata[0];
      end
      m_err = (wr || rd) && !ok;
      hist.push_front(min);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 mdc",       32'(mdc),  32'(m_mdc));
      check("R3 oe",        32'(moe),  32'(m_oe));
      check("R3 out",       32'(mout), 32'(m_out));
      check("R8 err",       32'(err),  32'(m_err));
      check("R5/R10 rdata", rdata,     m_rdata);
    end
  end

  task automatic op(bit w, bit r, logic [7:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; be = b; wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr = 0; rd = 0; addr = 0; be = 0; wdata = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    check("R1 reset mdc",   32'(mdc),  0);
    check("R1 reset oe",    32'(moe),  0);
    check("R1 reset out",   32'(mout), 0);
    check("R1 reset err",   32'(err),  0);
    check("R1 reset rdata", rdata,     0);
    rst_n = 1'b1;
    idle();
    check("R1 after reset mdc", 32'(mdc), 0);

    // R2/R3: drive 1 with clock high
    op(1, 0, 8'h28, 4'hF, 32'h7); idle();
    check("R2 mdc high", 32'(mdc), 1);
    check("R3 out set",  32'(mout), 1);
    // R3: drive disabled, data bit 0 ignored for out
    op(1, 0, 8'h28, 4'hF, 32'h4); idle();
    check("R3 oe low",  32'(moe), 0);
    check("R3 out kept", 32'(mout), 1);
    // R4: same clock level, no edge
    op(1, 0, 8'h28, 4'hF, 32'h6); idle();
    check("R4 mdc unchanged", 32'(mdc), 1);
    check("R3 out driven 0", 32'(mout), 0);
    // R6 readback of control
    op(0, 1, 8'h28, 4'hF, 0); idle();
    check("R6 ctrl readback", rdata, 32'h6);
    // R9 same-cycle write and read
    op(1, 1, 8'h28, 4'hF, 32'h3); idle();
    check("R9 read old state", rdata, 32'h6);
    check("R9 write landed",   32'(mdc), 0);
    // R10 hold
    idle();
    check("R10 rdata held", rdata, 32'h6);
    // R7 other word in window
    op(1, 0, 8'h00, 4'hF, 32'h4); idle();
    check("R7 write no effect", 32'(mdc), 0);
    check("R7 no error", 32'(err), 0);
    op(0, 1, 8'h58, 4'hF, 0); idle();
    check("R7 read zero", rdata, 0);
    // R8 narrow write
    op(1, 0, 8'h28, 4'h3, 32'h4); idle();
    check("R8 narrow ignored", 32'(mdc), 0);
    check("R8 err pulse", 32'(err), 1);
    idle();
    check("R8 err one cycle", 32'(err), 0);
    // R8 misaligned and out of window reads
    op(0, 1, 8'h29, 4'hF, 0); idle();
    check("R8 misaligned read zero", rdata, 0);
    op(0, 1, 8'h5C, 4'hF, 0); idle();
    check("R8 out of window err", 32'(err), 1);
    // R5 status follows line
    min = 1'b1;
    repeat (SYNC + 1) idle();
    op(0, 1, 8'h2C, 4'hF, 0); idle();
    check("R5 status high", rdata, 1);
    min = 1'b0;
    repeat (SYNC + 1) idle();
    op(0, 1, 8'h2C, 4'hF, 0); idle();
    check("R5 status low", rdata, 0);

    // Preamble-style bit-bang: 32 clock pulses with data 1 driven
    for (int i = 0; i < 32; i++) begin
      op(1, 0, 8'h28, 4'hF, 32'h3);
      op(1, 0, 8'h28, 4'hF, 32'h7);
    end
    idle();

    // Pseudo-random mix, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [3:0] b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:1])
        3'd0, 3'd1, 3'd2: a = 8'h28;
        3'd3, 3'd4:       a = 8'h2C;
        3'd5:             a = {lfsr[9:5], 2'b00};
        3'd6:             a = lfsr[15:8];
        default:          a = 8'h28 | {6'd0, lfsr[5:4]};
      endcase
      b = (lfsr[19:17] == 3'd0) ? lfsr[23:20] : 4'hF;
      min = lfsr[27];
      op(lfsr[11] | lfsr[12], lfsr[13], a, b, {lfsr[31:3], lfsr[26:24]});
    end
    idle();
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule